// File: doc/BRIEF.md
# Serial Port Status and Flag Core

This block is the status and flag logic of a single-channel asynchronous serial controller. Software reaches it over a byte-wide register bus that holds a mode register, a control register, a bit-rate register, a transmit-data register, a receive-data register and a status register. Received bytes arrive as a one-cycle strobe with a data byte. Bytes to send leave as a one-cycle strobe with a data byte. The serial line itself lies outside the block: wire timing, parity generation and interrupts are all handled elsewhere.

The status register holds four hardware flags: transmit-empty, transmit-end, receive-full and overrun. A flag is cleared only by a handshake. Software must first read the status register while the flag is 1. It may then clear the flag by writing 0 to it. Writing 1 to a flag never sets it. While the transmitter is disabled, both transmit flags are held at 1. When software clears transmit-empty, the byte in the transmit-data register goes out on the next cycle, and both transmit flags are then set again.

The block also computes the bit-rate divisor from the bit-rate register and a clock-select field. It exports the frame-format bits of the mode register, which the core stores but does not interpret.

Top module: `uart_flag_core`

## Requirements
- R1: After reset, the status register reads 0x84: transmit-empty (bit 7) and transmit-end (bit 2) are 1 and every other bit is 0. No flag has yet been read, so a status write of 0x00 issued before any status read clears nothing and sends nothing.
- R2: Suppose a byte strobe arrives while receive is enabled and receive-full (bit 6) is 0. The byte is stored and receive-full becomes 1.
- R3: Suppose a byte strobe arrives while receive-full is 1. Overrun (bit 5) becomes 1, and the stored byte keeps its old value.
- R4: A read of the receive-data register (address 5) returns the stored byte and clears receive-full.
- R5: A status write (address 4) clears flag bit 7, 6 or 5 only where the written bit is 0 and that flag has been read as 1 since it was last cleared. A written 1 never sets a flag. Bit 0 takes the written value, and bits 4, 3 and 1 read 0.
- R6: After every status write, the read-tracking state of each flag is ANDed with the written bit. Writing 1 to a flag that has been read keeps it clearable by a later write of 0.
- R7: A write to the transmit-data register (address 3) clears transmit-end while the transmitter is enabled.
- R8: Transmit-end is never 1 while transmit-empty is 0. Once a status write clears transmit-empty, the next cycle pulses the transmit strobe for one cycle with the transmit-data byte and sets both transmit flags again.
- R9: While the transmit-enable bit (control bit 5) is 0, transmit-empty and transmit-end stay 1 no matter what is written, and no byte is sent.
- R10: While the receive-enable bit (control bit 4) is 0, incoming byte strobes are ignored.
- R11: Two cycles after a write, the divisor output equals rate × 32 × 4^n, where rate is the bit-rate register (address 2) and n is mode bits 1:0.
- R12: The frame outputs follow mode (address 0) bits: 6 selects 7 data bits, 5 enables parity, 4 selects odd parity, and 3 selects 2 stop bits.
- R13: Read data appears on the bus one cycle after the read strobe. Mode, control, bit-rate and transmit-data read back their stored values, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| rx_stb | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| tx_stb | output | 1 | Byte to send valid, one cycle |
| tx_byte | output | 8 | Byte to send |
| rate_div | output | DIV_W | Bit-rate divisor |
| frame_7bit | output | 1 | 7 data bits selected |
| frame_par_en | output | 1 | Parity enabled |
| frame_par_odd | output | 1 | Odd parity selected |
| frame_stop2 | output | 1 | Two stop bits selected |

## Verification
The bench targets the following corner cases. Each one describes what a faulty design would do.
- A status write of 0 before any status read: a design that ignores read-tracking would clear transmit-empty and send a spurious byte.
- A second byte arriving while receive-full is still set: a faulty design would overwrite the stored byte or fail to raise overrun.
- A write of 1 to a flag that has been read, followed by a write of 0: a design that drops tracking on every write would leave the flag stuck.
- Disabling the transmitter or the receiver: a faulty design would let transmit flags drop or would accept bytes.
- Clock-select values and frame bits: a design with a wrong shift or a wrong bit position would produce the wrong divisor or frame outputs.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int DATA_W = 8;
  // register addresses
  localparam int REG_MODE = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_RATE = 2;
  localparam int REG_TXD  = 3;
  localparam int REG_STAT = 4;
  localparam int REG_RXD  = 5;
  // status bit positions
  localparam int ST_TXE   = 7;
  localparam int ST_RXF   = 6;
  localparam int ST_OVR   = 5;
  localparam int ST_TXEND = 2;
  // control bit positions
  localparam int CT_TE = 5;
  localparam int CT_RE = 4;
  // mode bit positions
  localparam int MD_CHR7  = 6;
  localparam int MD_PE    = 5;
  localparam int MD_ODD   = 4;
  localparam int MD_STOP2 = 3;
  // divisor base shift: multiply by 32
  localparam int BASE_SHIFT = 5;
endpackage

// File: rtl/uart_rate_calc.sv
module uart_rate_calc #(
  parameter int RATE_W = 8,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic [SEL_W-1:0]  sel,
  output logic [DIV_W-1:0]  div
);
  import uart_flag_pkg::*;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= DIV_W'(rate) << (BASE_SHIFT + 2 * int'(sel));
  end

  assign div = div_q;
endmodule

// File: rtl/uart_flag_status.sv
module uart_flag_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              te,
  input  logic              re,
  input  logic              st_wr,
  input  logic              st_rd,
  input  logic              td_wr,
  input  logic              rd_rx,
  input  logic [2:0]        wflags,
  input  logic              wbit0,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] txd,
  output logic [7:0]        status,
  output logic [2:0]        seen,
  output logic [DATA_W-1:0] rdr,
  output logic              tx_stb,
  output logic [DATA_W-1:0] tx_byte
);
  // flag vector order: {tx_empty, rx_full, overrun}
  logic [2:0]        flg_q, flg_n;
  logic [2:0]        seen_q, seen_n;
  logic              txend_q, txend_n;
  logic              b0_q, b0_n;
  logic [DATA_W-1:0] rdr_q, rdr_n;
  logic              send;
  logic              tx_stb_q;
  logic [DATA_W-1:0] tx_byte_q;

  always_comb begin
    flg_n   = flg_q;
    seen_n  = seen_q;
    txend_n = txend_q;
    b0_n    = b0_q;
    rdr_n   = rdr_q;
    send    = 1'b0;
    if (st_wr) begin
      flg_n  = flg_q & (~seen_q | wflags);
      seen_n = seen_q & wflags;
      b0_n   = wbit0;
    end
    if (st_rd) seen_n = seen_n | flg_q;
    if (td_wr) txend_n = 1'b0;
    if (rd_rx) flg_n[1] = 1'b0;
    if (rx_stb && re) begin
      if (flg_n[1]) flg_n[0] = 1'b1;
      else begin
        rdr_n    = rx_byte;
        flg_n[1] = 1'b1;
      end
    end
    if (!flg_q[2] && te) begin
      send     = 1'b1;
      flg_n[2] = 1'b1;
      txend_n  = 1'b1;
    end
    if (!te) begin
      flg_n[2] = 1'b1;
      txend_n  = 1'b1;
    end
    if (!flg_n[2]) txend_n = 1'b0;
    seen_n = seen_n & flg_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q     <= 3'b100;
      seen_q    <= '0;
      txend_q   <= 1'b1;
      b0_q      <= 1'b0;
      rdr_q     <= '0;
      tx_stb_q  <= 1'b0;
      tx_byte_q <= '0;
    end else begin
      flg_q    <= flg_n;
      seen_q   <= seen_n;
      txend_q  <= txend_n;
      b0_q     <= b0_n;
      rdr_q    <= rdr_n;
      tx_stb_q <= send;
      if (send) tx_byte_q <= txd;
    end
  end

  assign status  = {flg_q, 2'b00, txend_q, 1'b0, b0_q};
  assign seen    = seen_q;
  assign rdr     = rdr_q;
  assign tx_stb  = tx_stb_q;
  assign tx_byte = tx_byte_q;
endmodule

// File: rtl/uart_flag_core.sv
module uart_flag_core #(
  parameter int ADDR_W = 3,
  parameter int RATE_W = 8,
  parameter int SEL_W  = 2,
  localparam int DIV_W = RATE_W + 5 + 2 * ((1 << SEL_W) - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_stb,
  input  logic [7:0]        rx_byte,
  output logic              tx_stb,
  output logic [7:0]        tx_byte,
  output logic [DIV_W-1:0]  rate_div,
  output logic              frame_7bit,
  output logic              frame_par_en,
  output logic              frame_par_odd,
  output logic              frame_stop2
);
  import uart_flag_pkg::*;

  logic [7:0]        mode_q, ctrl_q, txd_q, rdata_q;
  logic [RATE_W-1:0] rate_q;
  logic [7:0]        status_byte, rdr;
  logic [2:0]        seen_bits;
  logic              st_wr, st_rd, td_wr, rd_rx;
  int                a;

  assign a     = int'(bus_addr);
  assign st_wr = bus_wr && a == REG_STAT;
  assign st_rd = bus_rd && a == REG_STAT;
  assign td_wr = bus_wr && a == REG_TXD;
  assign rd_rx = bus_rd && a == REG_RXD;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '0;
      rate_q <= '0;
      txd_q  <= '0;
    end else if (bus_wr) begin
      if (a == REG_MODE) mode_q <= bus_wdata;
      if (a == REG_CTRL) ctrl_q <= bus_wdata;
      if (a == REG_RATE) rate_q <= bus_wdata[RATE_W-1:0];
      if (a == REG_TXD)  txd_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      case (a)
        REG_MODE: rdata_q <= mode_q;
        REG_CTRL: rdata_q <= ctrl_q;
        REG_RATE: rdata_q <= 8'(rate_q);
        REG_TXD:  rdata_q <= txd_q;
        REG_STAT: rdata_q <= status_byte;
        REG_RXD:  rdata_q <= rdr;
        default:  rdata_q <= '0;
      endcase
    end
  end

  uart_flag_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .te(ctrl_q[CT_TE]), .re(ctrl_q[CT_RE]),
    .st_wr(st_wr), .st_rd(st_rd), .td_wr(td_wr), .rd_rx(rd_rx),
    .wflags(bus_wdata[7:5]), .wbit0(bus_wdata[0]),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .txd(txd_q),
    .status(status_byte), .seen(seen_bits), .rdr(rdr),
    .tx_stb(tx_stb), .tx_byte(tx_byte)
  );

  uart_rate_calc #(.RATE_W(RATE_W), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst(rst),
    .rate(rate_q), .sel(mode_q[SEL_W-1:0]), .div(rate_div)
  );

  assign bus_rdata     = rdata_q;
  assign frame_7bit    = mode_q[MD_CHR7];
  assign frame_par_en  = mode_q[MD_PE];
  assign frame_par_odd = mode_q[MD_ODD];
  assign frame_stop2   = mode_q[MD_STOP2];
endmodule

// File: rtl/uart_flag_core_chk.sv
module uart_flag_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       te,
  input logic       re,
  input logic       rx_stb,
  input logic       rd_rx,
  input logic       st_wr,
  input logic       td_wr,
  input logic       tx_stb,
  input logic [7:0] stat,
  input logic [2:0] seen
);
  // R3: byte into a full receiver raises overrun
  a_r3_overrun_on_full: assert property (@(posedge clk) disable iff (rst)
    rx_stb && re && stat[6] && !rd_rx |=> stat[5]);
  // R9: transmitter off holds both transmit flags
  a_r9_tx_flags_held: assert property (@(posedge clk) disable iff (rst)
    !te |=> stat[7] && stat[2]);
  // R8: transmit-end never set while transmit-empty is clear
  a_r8_txend_needs_txe: assert property (@(posedge clk) disable iff (rst)
    !stat[7] |-> !stat[2]);
  // R8: a sent byte comes with both transmit flags set
  a_r8_send_sets_flags: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> stat[7] && stat[2]);
  // R5: a status write never raises overrun
  a_r5_write_no_set: assert property (@(posedge clk) disable iff (rst)
    st_wr && !rx_stb && !stat[5] |=> !stat[5]);
  // R6: read-tracking only covers flags that are set
  a_r6_seen_subset: assert property (@(posedge clk) disable iff (rst)
    (seen & ~stat[7:5]) == 3'b000);
  // R7: transmit-data write drops transmit-end
  a_r7_txd_clears_end: assert property (@(posedge clk) disable iff (rst)
    td_wr && te && stat[7] |=> !stat[2]);
endmodule

bind uart_flag_core uart_flag_core_chk i_chk (
  .clk(clk), .rst(rst),
  .te(ctrl_q[5]), .re(ctrl_q[4]),
  .rx_stb(rx_stb), .rd_rx(rd_rx), .st_wr(st_wr), .td_wr(td_wr),
  .tx_stb(tx_stb), .stat(status_byte), .seen(seen_bits)
);

// File: tb/test_uart_flag_core.sv
module test_uart_flag_core;
  localparam int DIV_W = 19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       bus_addr = '0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]       bus_wdata = '0;
  logic [7:0]       bus_rdata;
  logic             rx_stb = 1'b0;
  logic [7:0]       rx_byte = '0;
  logic             tx_stb;
  logic [7:0]       tx_byte;
  logic [DIV_W-1:0] rate_div;
  logic             f7, fpe, fodd, fst2;

  int checks = 0, errors = 0, tx_cnt = 0;
  logic [7:0] last_tx = '0;
  bit done = 0;

  // bench model
  logic m_txe, m_txend, m_rxf, m_ovr, m_b0, m_te, m_re;
  logic [2:0] m_seen;
  logic [7:0] m_rdr, m_txd;
  int m_sends;

  uart_flag_core i_uart_flag_core (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .rate_div(rate_div), .frame_7bit(f7),
    .frame_par_en(fpe), .frame_par_odd(fodd), .frame_stop2(fst2)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (tx_stb) begin
    tx_cnt++;
    last_tx = tx_byte;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_txe, m_rxf, m_ovr, 2'b00, m_txend, 1'b0, m_b0};
  endfunction

  function automatic logic [DIV_W-1:0] exp_div(logic [7:0] rate, logic [1:0] sel);
    return DIV_W'(rate) * 32 * (4 ** sel);
  endfunction

  task automatic m_mask();
    m_seen = m_seen & {m_txe, m_rxf, m_ovr};
  endtask

  task automatic bus_write(int a, logic [7:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic op_ctrl(logic [7:0] v);
    bus_write(1, v);
    m_te = v[5]; m_re = v[4];
    if (!m_te) begin m_txe = 1; m_txend = 1; end
  endtask

  task automatic op_stat_rd(string tag);
    logic [7:0] d;
    bus_read(4, d);
    check(tag, d, m_status());
    m_seen = m_seen | {m_txe, m_rxf, m_ovr};
  endtask

  task automatic op_stat_wr(logic [7:0] w);
    logic [2:0] f;
    bus_write(4, w);
    f = {m_txe, m_rxf, m_ovr} & (~m_seen | w[7:5]);
    {m_txe, m_rxf, m_ovr} = f;
    m_seen = m_seen & w[7:5];
    m_b0 = w[0];
    if (!m_te) begin m_txe = 1; m_txend = 1; end
    if (!m_txe) m_txend = 0;
    m_mask();
    if (!m_txe) begin m_txe = 1; m_txend = 1; m_sends++; end
  endtask

  task automatic op_txd(logic [7:0] v);
    bus_write(3, v);
    m_txd = v;
    if (m_te) m_txend = 0;
  endtask

  task automatic op_push(logic [7:0] b);
    @(negedge clk);
    rx_stb = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_stb = 1'b0;
    if (m_re) begin
      if (m_rxf) m_ovr = 1;
      else begin m_rdr = b; m_rxf = 1; end
    end
  endtask

  task automatic op_rxd_rd(string tag);
    logic [7:0] d;
    bus_read(5, d);
    check(tag, d, m_rdr);
    m_rxf = 0;
    m_mask();
  endtask

  initial begin
    logic [7:0] d;
    int sends_before;
    void'($urandom(32'h5EED_1234));
    m_txe = 1; m_txend = 1; m_rxf = 0; m_ovr = 0; m_b0 = 0; m_te = 0; m_re = 0;
    m_seen = 0; m_rdr = 0; m_txd = 0; m_sends = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(0, d); check("R1 mode after reset", d, 8'h00);
    bus_read(1, d); check("R1 ctrl after reset", d, 8'h00);
    op_ctrl(8'h30);
    op_stat_wr(8'h00);
    repeat (2) @(negedge clk);
    check("R1 no send without prior read", tx_cnt, 0);
    op_stat_rd("R1 status after reset");
    check("R1 reset status constant", m_status(), 8'h84);

    // R7 / R6 / R8
    op_txd(8'h5A);
    op_stat_rd("R7 txd write clears tx end");
    op_stat_wr(8'h81);
    op_stat_wr(8'h00);
    repeat (2) @(negedge clk);
    check("R8 one byte sent", tx_cnt, 1);
    check("R8 sent byte", last_tx, 8'h5A);
    check("R6 send count", tx_cnt, m_sends);
    op_stat_rd("R8 flags restored");
    op_stat_wr(8'h81);
    op_stat_rd("R5 bit0 written directly");

    // R2 / R3 / R4 / R5
    op_push(8'h3C);
    op_stat_rd("R2 rx full set");
    op_push(8'h77);
    op_stat_rd("R3 overrun set");
    op_rxd_rd("R3 R4 stored byte kept");
    op_stat_rd("R4 rx full cleared");
    op_stat_wr(8'hC1);
    op_stat_rd("R5 overrun cleared after read");
    op_push(8'h12);
    op_stat_wr(8'h81);
    op_stat_rd("R5 unread rx full not cleared");

    // R10
    op_ctrl(8'h20);
    op_push(8'h99);
    op_stat_rd("R10 no overrun while rx disabled");
    op_rxd_rd("R10 byte ignored");

    // R9
    op_ctrl(8'h00);
    sends_before = tx_cnt;
    op_stat_rd("R9 flags with tx off");
    op_stat_wr(8'h00);
    op_txd(8'hA5);
    repeat (2) @(negedge clk);
    op_stat_rd("R9 tx flags held");
    check("R9 nothing sent", tx_cnt, sends_before);

    // R11 / R12
    bus_write(0, 8'h7A); bus_write(2, 8'd3);
    @(negedge clk);
    check("R11 divisor sel2", rate_div, exp_div(8'd3, 2'd2));
    check("R12 frame fields", {f7, fpe, fodd, fst2}, 4'b1111);
    bus_write(0, 8'h03); bus_write(2, 8'd255);
    @(negedge clk);
    check("R11 divisor sel3", rate_div, exp_div(8'd255, 2'd3));
    check("R12 frame fields cleared", {f7, fpe, fodd, fst2}, 4'b0000);
    bus_write(0, 8'h50);
    @(negedge clk);
    check("R11 divisor sel0", rate_div, exp_div(8'd255, 2'd0));
    check("R12 frame 7bit odd", {f7, fpe, fodd, fst2}, 4'b1010);

    // R13
    bus_read(6, d); check("R13 unused address", d, 8'h00);
    bus_read(7, d); check("R13 unused address 7", d, 8'h00);
    bus_read(3, d); check("R13 txd readback", d, m_txd);
    bus_read(2, d); check("R13 rate readback", d, 8'd255);

    // random mix with transmitter and receiver on
    op_ctrl(8'h30);
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 5)
        0: op_push(8'($urandom));
        1: op_stat_rd("R5 random status");
        2: op_stat_wr(8'($urandom));
        3: op_rxd_rd("R4 random rx data");
        default: op_txd(8'($urandom));
      endcase
    end
    repeat (2) @(negedge clk);
    check("R8 random send count", tx_cnt, m_sends);
    op_stat_rd("R6 final status");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule